// File: doc/BRIEF.md
# Capacitive Key Matrix Scan Sequencer

This block runs one acquisition pass over a grid of touch keys laid out as `NUM_X` drive columns by `NUM_Y` receive rows. By default the grid is 8 by 3, giving 24 key positions. A key's index is its row times `NUM_X` plus its column. The scan visits keys in index order, so the column advances fastest.

For every enabled key the block does the following:
- It emits a burst of drive pulses on that key's X line. The key's own entry in a burst-length table sets how many pulses there are.
- While a pulse is high it opens the gate of the key's Y line. While the pulse is low it clamps that line.
- After the last pulse it clamps the line for one more dwell period.
- It then enables a single-slope ramp and counts clock cycles until the zero-crossing comparator input rises. That count is the key's raw signal.

Disabled keys use no timeslot at all.

A scan starts on a strobe. The key-enable mask and the calibration request are captured when the scan starts. A start is refused if the mask enables more keys than the configured limit `MAX_KEYS`. When the calibration request is captured, every result of that scan is also stored as the key's reference. Every result reports the reference that was held before the new one was stored.

Top module: `kms_scan_seq`

## Requirements
- R1: Keys are converted in ascending index order. During a key's pulses only X line `index % NUM_X` is driven and only Y gate `index / NUM_X` is open. `res_key` carries the index.
- R2: Keys whose bit in `key_en` is clear get no pulses and no result. A key's first X pulse starts exactly one cycle after the previous key's result strobe, however many disabled keys lie between them.
- R3: A key receives as many X pulses as its field `burst_len[k*BL_W +: BL_W]` holds. A value of zero gives one pulse.
- R4: Each X pulse is high for exactly `DWELL_CYC` cycles with the row's gate open. It is then low for `DWELL_CYC` cycles with that row's clamp asserted.
- R5: After the last pulse the row stays clamped for `DWELL_CYC` more cycles, and only then is `ramp_en` raised. No X pulse occurs while `ramp_en` is high.
- R6: The result count equals the number of ramp cycles that preceded the first ramp cycle in which `zc_in` was high. That is 0 when `zc_in` is high in the first ramp cycle. `res_valid` pulses for one cycle in the cycle after that.
- R7: If the count reaches its all-ones maximum without a zero crossing, the result is that maximum with `res_timeout` set. Otherwise `res_timeout` is clear.
- R8: A `scan_start` while `key_en` has more than `MAX_KEYS` bits set starts no scan. In that case `start_reject` pulses for one cycle.
- R9: `scan_done` pulses once, in the cycle after the last enabled key's result. With no key enabled, it pulses without any result.
- R10: `res_ref` reports the key's stored reference from before this result, with all references zero after reset. A scan started with `cal_req` high stores each of its results as that key's new reference.
- R11: In reset all outputs are low.
- R12: A `scan_start` while a scan is running is ignored: the running scan completes once and no second scan follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | Strobe that begins a scan |
| cal_req | input | 1 | Store this scan's results as references (sampled with the strobe) |
| key_en | input | NUM_KEYS | Per-key enable mask |
| burst_len | input | NUM_KEYS*BL_W | Per-key pulse counts, key k at bits k*BL_W |
| zc_in | input | 1 | Zero-crossing comparator |
| x_drive | output | NUM_X | Column drive pulses |
| y_gate | output | NUM_Y | Row capture gate |
| y_clamp | output | NUM_Y | Row clamp to ground |
| ramp_en | output | 1 | Conversion ramp running |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Result strobe |
| res_key | output | IDX_W | Index of the converted key |
| res_count | output | CNT_W | Conversion count |
| res_timeout | output | 1 | Count saturated without a crossing |
| res_ref | output | CNT_W | Key's reference before this result |
| scan_done | output | 1 | Last enabled key finished |
| start_reject | output | 1 | Start refused, too many keys enabled |

## Verification
On every cycle, the assertions check four things:
- the one-column drive and the exact high width of each pulse;
- the pulse count against the captured burst length;
- that the clamp precedes the ramp;
- that results arrive in ascending order and only for enabled keys.

Saturation is also checked on every cycle, together with the idle state around `scan_done` and `start_reject`.

Some behaviour only the bench scenarios can show:
- the count value tied to the comparator timing;
- the single-cycle gap across skipped keys;
- the reference contents carried from a calibration scan into later scans;
- the rejection at one key over the limit, set against acceptance exactly at it;
- that a second strobe during a scan has no effect.

// File: rtl/kms_pkg.sv
package kms_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEEK,
      ST_HI,
      ST_LO,
      ST_CLAMP,
      ST_RAMP
   } seq_state_t;

endpackage

// File: rtl/kms_popcount.sv
module kms_popcount #(
   parameter int N   = 24,
   parameter int CW  = 5
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] ones
);

   always_comb begin
      ones = '0;
      for (int i = 0; i < N; i++) begin
         ones = ones + CW'(vec[i]);
      end
   end

endmodule

// File: rtl/kms_key_finder.sv
module kms_key_finder #(
   parameter int NUM_KEYS = 24,
   parameter int IDX_W    = 5
) (
   input  logic [NUM_KEYS-1:0] mask,
   input  logic [IDX_W-1:0]    from,
   output logic                found,
   output logic [IDX_W-1:0]    idx
);

   // lowest set bit at or above 'from'; scanning downward lets the last hit win
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_KEYS - 1; i >= 0; i--) begin
         if (mask[i] && (IDX_W'(i) >= from)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/kms_ramp_counter.sv
module kms_ramp_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             at_max
);

   assign at_max = &cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (!at_max) cnt <= cnt + CNT_W'(1);
   end

   AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$past(at_max) |-> cnt == $past(cnt) + CNT_W'(1)); // R6

   AST_RAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && $past(at_max) |-> at_max); // R7

endmodule

// File: rtl/kms_ref_store.sv
module kms_ref_store #(
   parameter int NUM_KEYS = 24,
   parameter int IDX_W    = 5,
   parameter int CNT_W    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_data
);

   logic [CNT_W-1:0] mem [NUM_KEYS];

   for (genvar g = 0; g < NUM_KEYS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 mem[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))    mem[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = mem[i];
      end
   end

endmodule

// File: rtl/kms_scan_seq.sv
module kms_scan_seq
   import kms_pkg::*;
#(
   parameter  int NUM_X     = 8,
   parameter  int NUM_Y     = 3,
   parameter  int MAX_KEYS  = 24,
   parameter  int BL_W      = 6,
   parameter  int CNT_W     = 10,
   parameter  int DWELL_CYC = 4,
   localparam int NUM_KEYS  = NUM_X * NUM_Y,
   localparam int IDX_W     = $clog2(NUM_KEYS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scan_start,
   input  logic                     cal_req,
   input  logic [NUM_KEYS-1:0]      key_en,
   input  logic [NUM_KEYS*BL_W-1:0] burst_len,
   input  logic                     zc_in,
   output logic [NUM_X-1:0]         x_drive,
   output logic [NUM_Y-1:0]         y_gate,
   output logic [NUM_Y-1:0]         y_clamp,
   output logic                     ramp_en,
   output logic                     busy,
   output logic                     res_valid,
   output logic [IDX_W-1:0]         res_key,
   output logic [CNT_W-1:0]         res_count,
   output logic                     res_timeout,
   output logic [CNT_W-1:0]         res_ref,
   output logic                     scan_done,
   output logic                     start_reject
);

   localparam int XW   = $clog2(NUM_X);
   localparam int YW   = $clog2(NUM_Y);
   localparam int DW_W = $clog2(DWELL_CYC);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // elaboration-time parameter checks
   if (NUM_X < 2 || NUM_Y < 2) begin : g_bad_grid
      $error("kms_scan_seq: grid needs at least 2 columns and 2 rows");
   end
   if (MAX_KEYS < 1 || MAX_KEYS > NUM_KEYS) begin : g_bad_limit
      $error("kms_scan_seq: MAX_KEYS out of range");
   end
   if (DWELL_CYC < 2) begin : g_bad_dwell
      $error("kms_scan_seq: DWELL_CYC must be at least 2");
   end
   if (BL_W < 1 || CNT_W < 2) begin : g_bad_width
      $error("kms_scan_seq: width parameters too small");
   end

   seq_state_t          state;
   logic [NUM_KEYS-1:0] en_q;
   logic                cal_q;
   logic [IDX_W-1:0]    cur_key;
   logic [IDX_W-1:0]    seek_base;
   logic [DW_W-1:0]     dw_cnt;
   logic [BL_W-1:0]     pulse_cnt;
   logic [BL_W-1:0]     bl_last;

   logic                fnd;
   logic [IDX_W-1:0]    fnd_idx;
   logic [IDX_W-1:0]    en_ones;
   logic                over_limit;
   logic [BL_W-1:0]     bl_sel;
   logic                dwell_end;
   logic [CNT_W-1:0]    ramp_cnt;
   logic                ramp_max;
   logic                conv_end;
   logic [CNT_W-1:0]    ref_rd;
   logic [XW-1:0]       cur_x;
   logic [YW-1:0]       cur_y;

   // ---------------------------------------------------------------- helpers
   kms_popcount #(.N(NUM_KEYS), .CW(IDX_W)) u_pop (
      .vec  (key_en),
      .ones (en_ones)
   );

   kms_key_finder #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_find (
      .mask  (en_q),
      .from  (seek_base),
      .found (fnd),
      .idx   (fnd_idx)
   );

   kms_ramp_counter #(.CNT_W(CNT_W)) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == ST_RAMP),
      .cnt    (ramp_cnt),
      .at_max (ramp_max)
   );

   kms_ref_store #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (conv_end && cal_q),
      .wr_idx  (cur_key),
      .wr_data (zc_in ? ramp_cnt : CNT_MAX),
      .rd_idx  (cur_key),
      .rd_data (ref_rd)
   );

   assign over_limit = en_ones > IDX_W'(MAX_KEYS);
   assign bl_sel     = burst_len[fnd_idx*BL_W +: BL_W];
   assign dwell_end  = dw_cnt == DW_W'(DWELL_CYC - 1);
   assign conv_end   = (state == ST_RAMP) && (zc_in || ramp_max);

   // key index to column / row: cheap slicing for a power-of-two column count
   if ((NUM_X & (NUM_X - 1)) == 0) begin : g_pow2_cols
      assign cur_x = cur_key[XW-1:0];
      assign cur_y = YW'(cur_key >> XW);
   end else begin : g_div_cols
      assign cur_x = XW'(int'(cur_key) % NUM_X);
      assign cur_y = YW'(int'(cur_key) / NUM_X);
   end

   // ---------------------------------------------------------------- sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         en_q         <= '0;
         cal_q        <= 1'b0;
         cur_key      <= '0;
         seek_base    <= '0;
         dw_cnt       <= '0;
         pulse_cnt    <= '0;
         bl_last      <= '0;
         res_valid    <= 1'b0;
         res_key      <= '0;
         res_count    <= '0;
         res_timeout  <= 1'b0;
         res_ref      <= '0;
         scan_done    <= 1'b0;
         start_reject <= 1'b0;
      end else begin
         res_valid    <= 1'b0;
         scan_done    <= 1'b0;
         start_reject <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (scan_start) begin
                  if (over_limit) begin
                     start_reject <= 1'b1;
                  end else begin
                     en_q      <= key_en;
                     cal_q     <= cal_req;
                     seek_base <= '0;
                     state     <= ST_SEEK;
                  end
               end
            end
            ST_SEEK: begin
               if (fnd) begin
                  cur_key   <= fnd_idx;
                  bl_last   <= (bl_sel == '0) ? '0 : bl_sel - BL_W'(1);
                  pulse_cnt <= '0;
                  dw_cnt    <= '0;
                  state     <= ST_HI;
               end else begin
                  scan_done <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            ST_HI: begin
               dw_cnt <= dw_cnt + DW_W'(1);
               if (dwell_end) begin
                  dw_cnt <= '0;
                  state  <= ST_LO;
               end
            end
            ST_LO: begin
               dw_cnt <= dw_cnt + DW_W'(1);
               if (dwell_end) begin
                  dw_cnt <= '0;
                  if (pulse_cnt == bl_last) begin
                     state <= ST_CLAMP;
                  end else begin
                     pulse_cnt <= pulse_cnt + BL_W'(1);
                     state     <= ST_HI;
                  end
               end
            end
            ST_CLAMP: begin
               dw_cnt <= dw_cnt + DW_W'(1);
               if (dwell_end) begin
                  dw_cnt <= '0;
                  state  <= ST_RAMP;
               end
            end
            ST_RAMP: begin
               if (conv_end) begin
                  res_valid   <= 1'b1;
                  res_key     <= cur_key;
                  res_count   <= zc_in ? ramp_cnt : CNT_MAX;
                  res_timeout <= !zc_in;
                  res_ref     <= ref_rd;
                  seek_base   <= cur_key + IDX_W'(1);
                  state       <= ST_SEEK;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // ---------------------------------------------------------------- line drivers
   for (genvar gx = 0; gx < NUM_X; gx++) begin : g_xdrv
      assign x_drive[gx] = (state == ST_HI) && (cur_x == XW'(gx));
   end

   for (genvar gy = 0; gy < NUM_Y; gy++) begin : g_ydrv
      assign y_gate[gy]  = (state == ST_HI) && (cur_y == YW'(gy));
      assign y_clamp[gy] = ((state == ST_LO) || (state == ST_CLAMP)) && (cur_y == YW'(gy));
   end

   assign ramp_en = state == ST_RAMP;
   assign busy    = state != ST_IDLE;

   // ---------------------------------------------------------------- checks
   logic [DW_W:0]    hi_run;
   logic [BL_W:0]    pulses_seen;
   logic [IDX_W-1:0] last_res_key;
   logic             res_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run       <= '0;
         pulses_seen  <= '0;
         last_res_key <= '0;
         res_seen     <= 1'b0;
      end else begin
         hi_run <= (|x_drive) ? hi_run + (DW_W+1)'(1) : '0;
         if (state == ST_SEEK)
            pulses_seen <= '0;
         else if ((|x_drive) && (hi_run == '0))
            pulses_seen <= pulses_seen + (BL_W+1)'(1);
         if (state == ST_IDLE)
            res_seen <= 1'b0;
         else if (res_valid) begin
            res_seen     <= 1'b1;
            last_res_key <= res_key;
         end
      end
   end

   AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(x_drive) && $onehot0(y_gate) && $onehot0(y_clamp)); // R1

   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_seen |-> res_key > last_res_key); // R1

   AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> en_q[res_key]); // R2

   AST_PULSE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ramp_en) |-> pulses_seen == {1'b0, bl_last} + (BL_W+1)'(1)); // R3

   AST_DWELL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|x_drive) |-> hi_run == (DW_W+1)'(DWELL_CYC)); // R4

   AST_CLAMP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ramp_en) |-> $past(|y_clamp)); // R5

   AST_TIMEOUT_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_timeout |-> res_count == CNT_MAX); // R7

   AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_reject |-> !busy); // R8

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> !busy && !res_valid); // R9

endmodule

// File: tb/tb_kms_scan_seq.sv
module tb_kms_scan_seq;

   localparam int NX   = 8;
   localparam int NY   = 3;
   localparam int NK   = NX * NY;
   localparam int BLW  = 6;
   localparam int CW   = 10;
   localparam int DW   = 4;
   localparam int MAXK = 16;
   localparam int IW   = $clog2(NK + 1);
   localparam int CMAX = (1 << CW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              scan_start = 1'b0;
   logic              cal_req = 1'b0;
   logic [NK-1:0]     key_en = '0;
   logic [NK*BLW-1:0] burst_len = '0;
   logic              zc_in = 1'b0;
   logic [NX-1:0]     x_drive;
   logic [NY-1:0]     y_gate;
   logic [NY-1:0]     y_clamp;
   logic              ramp_en;
   logic              busy;
   logic              res_valid;
   logic [IW-1:0]     res_key;
   logic [CW-1:0]     res_count;
   logic              res_timeout;
   logic [CW-1:0]     res_ref;
   logic              scan_done;
   logic              start_reject;

   always #5 clk = ~clk;

   kms_scan_seq #(
      .NUM_X(NX), .NUM_Y(NY), .MAX_KEYS(MAXK), .BL_W(BLW), .CNT_W(CW), .DWELL_CYC(DW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .cal_req(cal_req),
      .key_en(key_en), .burst_len(burst_len), .zc_in(zc_in),
      .x_drive(x_drive), .y_gate(y_gate), .y_clamp(y_clamp), .ramp_en(ramp_en),
      .busy(busy), .res_valid(res_valid), .res_key(res_key), .res_count(res_count),
      .res_timeout(res_timeout), .res_ref(res_ref), .scan_done(scan_done),
      .start_reject(start_reject)
   );

   // scan vectors: enable mask, burst-length base, crossing-time base, calibrate
   localparam int NV = 6;
   localparam logic [NK-1:0] V_MASK [NV] = '{24'h0000FF, 24'h0000FF, 24'h810401,
                                            24'hF0F0F0, 24'h00FFFF, 24'h000000};
   localparam int V_BL  [NV] = '{1, 2, 0, 3, 4, 1};
   localparam int V_TGT [NV] = '{5, 20, 0, 40, 9, 3};
   localparam bit V_CAL [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

   int n_vec = 0;
   int n_err = 0;
   bit finished = 1'b0;

   int bl_k  [NK];
   int tgt_k [NK];
   int ref_m [NK];
   logic [NK-1:0] mask_m = '0;
   bit cal_m = 1'b0;
   int last_key = -1;
   int pulses = 0, hi_cyc = 0, px = 0, py = 0, gap = 0, rc = 0;
   bit gap_armed = 1'b0;
   int done_cnt = 0, res_cnt = 0;
   logic [NX-1:0] prev_x = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int next_en(input int from);
      for (int k = from; k < NK; k++) if (mask_m[k]) return k;
      return NK;
   endfunction

   // monitor and comparator model, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         int cur;
         int ec;
         bit et;
         cur = next_en(last_key + 1);
         if (ramp_en) begin
            zc_in = (cur < NK) && (rc == tgt_k[cur]);
            rc++;
         end else begin
            zc_in = 1'b0;
            rc = 0;
         end
         if (gap_armed) gap++;
         if ((|x_drive) && (prev_x == '0)) begin
            pulses++;
            for (int i = 0; i < NX; i++) if (x_drive[i]) px = i;
            for (int i = 0; i < NY; i++) if (y_gate[i]) py = i;
            if (gap_armed) chk(gap == 1, "R2 slot gap", gap, 1);
            gap_armed = 1'b0;
         end
         if (|x_drive) hi_cyc++;
         prev_x = x_drive;
         if (res_valid) begin
            et = tgt_k[cur] > CMAX;
            ec = et ? CMAX : tgt_k[cur];
            chk(int'(res_key) == cur, "R1 key order", int'(res_key), cur);
            chk(px == cur % NX, "R1 column", px, cur % NX);
            chk(py == cur / NX, "R1 row", py, cur / NX);
            chk(pulses == ((bl_k[cur] == 0) ? 1 : bl_k[cur]), "R3 pulse count", pulses,
                (bl_k[cur] == 0) ? 1 : bl_k[cur]);
            chk(hi_cyc == pulses * DW, "R4 high time", hi_cyc, pulses * DW);
            chk(int'(res_count) == ec, "R6 count", int'(res_count), ec);
            chk(res_timeout == et, "R7 timeout flag", int'(res_timeout), int'(et));
            chk(int'(res_ref) == ref_m[cur], "R10 reference", int'(res_ref), ref_m[cur]);
            if (cal_m) ref_m[cur] = ec;
            last_key = cur;
            pulses = 0;
            hi_cyc = 0;
            gap = 0;
            gap_armed = 1'b1;
            res_cnt++;
         end
         if (scan_done) begin
            chk(next_en(last_key + 1) == NK, "R9 done after last key",
                next_en(last_key + 1), NK);
            done_cnt++;
         end
      end
   end

   task automatic run_scan(input logic [NK-1:0] mask, input int blb, input int tgtb,
                           input bit cal, input bit retrig);
      int guard;
      mask_m = mask;
      cal_m  = cal;
      for (int k = 0; k < NK; k++) begin
         bl_k[k]  = (blb + k) % 5;
         tgt_k[k] = tgtb + (k * 7) % 13;
         burst_len[k*BLW +: BLW] = BLW'(bl_k[k]);
      end
      last_key = -1; pulses = 0; hi_cyc = 0; gap_armed = 1'b0;
      done_cnt = 0; res_cnt = 0;
      @(negedge clk);
      key_en = mask; cal_req = cal; scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0; cal_req = 1'b0;
      guard = 0;
      while (done_cnt == 0 && guard < 30000) begin
         @(posedge clk);
         guard++;
         if (retrig && guard == 10) begin
            @(negedge clk) scan_start = 1'b1;
            @(negedge clk) scan_start = 1'b0;
         end
      end
      chk(done_cnt == 1, "R9 scan finished", done_cnt, 1);
      chk(res_cnt == $countones(mask), "R2 one result per enabled key", res_cnt,
          $countones(mask));
   endtask

   initial begin
      for (int k = 0; k < NK; k++) ref_m[k] = 0;
      // R11: reset state
      repeat (3) @(negedge clk);
      chk({x_drive, y_gate, y_clamp, ramp_en, busy, res_valid, scan_done, start_reject} == '0,
          "R11 reset outputs", int'({x_drive, y_gate, y_clamp}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !ramp_en, "R11 idle after reset", int'(busy), 0);

      // table walk
      for (int v = 0; v < NV; v++) run_scan(V_MASK[v], V_BL[v], V_TGT[v], V_CAL[v], 1'b0);

      // R7: crossing never arrives for two keys
      run_scan(24'h800001, 2, 1100, 1'b0, 1'b0);

      // R12: second strobe during a running scan
      run_scan(24'h000003, 1, 60, 1'b0, 1'b1);
      repeat (30) @(negedge clk);
      chk(done_cnt == 1 && !busy, "R12 no second scan", done_cnt, 1);

      // R8: one key over the limit
      @(negedge clk);
      key_en = 24'h01FFFF; scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      chk(start_reject == 1'b1, "R8 reject strobe", int'(start_reject), 1);
      chk(!busy, "R8 no scan", int'(busy), 0);
      begin
         int act = 0;
         repeat (20) begin
            @(negedge clk);
            if (busy || (|x_drive) || start_reject) act++;
         end
         chk(act == 0, "R8 stays idle", act, 0);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      #1_900_000;
      if (!finished) begin
         n_err++;
         n_vec++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end

endmodule